// File: doc/BRIEF.md
# UART Receive Path with Tagged FIFO and Line Status

This block receives asynchronous serial characters on a single line, samples them at sixteen times the bit rate, and assembles each character in a shift register. Every finished character is written into a receive FIFO together with three error tags: parity, framing and break. The tags travel with the character, so the status a CPU reads always describes the character it will pop next.

A CPU-side read port selects either the receive buffer or the line status register. Reading the buffer pops the FIFO. Reading the status register clears the sticky overrun flag and re-evaluates a FIFO-wide error summary bit. Configuration inputs choose the character length, whether parity is present and its sense, and whether the FIFO is enabled. A bit-rate enable pulse supplies the sixteen-times sample rate.

The receiver treats two line conditions specially. A low stop bit is taken as the start bit of the next character, so the receiver resynchronises at once. A line held low for an entire character time is stored as a break character, after which the receiver waits for the line to go high before it looks for another start bit.

Top module: `uart_rx_lsr`

## Requirements
- R1: Status bit 0 (ready) is 1 exactly when the FIFO holds at least one unread character.
- R2: When a character completes while the FIFO is full, that character is discarded, the stored entries are unchanged, and status bit 1 (overrun) becomes 1 and stays 1 until the next status read, which clears it.
- R3: With cfg_par_en high, one parity bit follows the data bits. cfg_par_odd=0 expects an even count of ones over data plus parity, cfg_par_odd=1 an odd count. A mismatch tags the character, and status bit 2 shows the tag of the head character.
- R4: A stop bit sampled low tags the character with a framing error, shown in status bit 3 while that character is at the head.
- R5: After a framing error the low stop bit is taken as the start bit of the next character: the data bits that follow it are received without a fresh start bit.
- R6: If the line stays low through start, data, parity and stop, a character of value 0 is stored with status bit 4 (break) and bit 3 (framing) set, and no parity tag. The receiver then accepts nothing until the line has returned high.
- R7: Status bit 7 (error summary) is set when a character with any tag enters the FIFO. A status read clears it only if no tagged character remains in the FIFO. It reads 0 whenever cfg_fifo_en is low.
- R8: A falling edge starts a character only if the line is still low at the eighth sample. Otherwise the receiver returns to idle and stores nothing.
- R9: cfg_len values 0 to 3 select 5 to 8 data bits. Data arrives least significant bit first and is right-aligned in the buffer with upper bits zero.
- R10: A buffer read (rd_sel=0) returns the head data and pops it. On an empty FIFO the read returns 0 and changes nothing. Status bits 2 to 4 follow the new head after each pop.
- R11: With cfg_fifo_en low the FIFO holds a single character, so a second character arriving before a buffer read causes an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Sample enable, OSR pulses per bit |
| rxd | input | 1 | Serial receive line, high when idle |
| cfg_len | input | 2 | Data length select, 0..3 for 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_fifo_en | input | 1 | 1 enables the multi-entry FIFO |
| rd_en | input | 1 | Read strobe, side effects at the clock edge |
| rd_sel | input | 1 | 0 selects the receive buffer, 1 the status register |
| rd_data | output | DATA_W | Read data, combinational from rd_sel |

## Verification
The bench builds the block with its default values: 8 data bits, a 16-entry FIFO, 16 samples per bit and a two-stage synchroniser. It holds baud_tick high, so one bit lasts 16 clocks. That makes it cheap to fill the whole FIFO and overrun it, and to hold a break for many character times. The short bit time also lets a resynchronised character follow a framing error back to back, and it keeps the false-start and 5-bit length cases well inside the run limit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_BRK
   } rx_state_e;

   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rx_tag_t;

   localparam int unsigned TAG_W    = 3;
   localparam int unsigned LSR_RDY  = 0;
   localparam int unsigned LSR_OVR  = 1;
   localparam int unsigned LSR_PAR  = 2;
   localparam int unsigned LSR_FRM  = 3;
   localparam int unsigned LSR_BRK  = 4;
   localparam int unsigned LSR_SUM  = 7;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
   import uart_rx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   output logic              char_vld,
   output logic [DATA_W-1:0] char_data,
   output rx_tag_t           char_tag,
   output rx_state_e         state
);
   localparam int unsigned CNT_W = $clog2(OSR);
   localparam int unsigned IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W:0]    nbits;
   logic [DATA_W-1:0] shreg;
   logic              par_bit;
   logic              seen_one;
   logic              is_brk;
   logic              par_bad;

   assign nbits   = (IDX_W+1)'(DATA_W - 3) + (IDX_W+1)'(cfg_len);
   assign is_brk  = !rx && !seen_one;
   assign par_bad = cfg_par_en && ((^shreg ^ par_bit) != cfg_par_odd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         cnt       <= '0;
         idx       <= '0;
         shreg     <= '0;
         par_bit   <= 1'b0;
         seen_one  <= 1'b0;
         char_vld  <= 1'b0;
         char_data <= '0;
         char_tag  <= '0;
      end else begin
         char_vld <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (tick && !rx) begin
                  state <= RX_START;
                  cnt   <= '0;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (cnt == MID) begin
                     cnt <= '0;
                     if (!rx) begin
                        state    <= RX_DATA;
                        idx      <= '0;
                        shreg    <= '0;
                        seen_one <= 1'b0;
                     end else begin
                        state <= RX_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (tick) begin
                  if (cnt == LAST) begin
                     cnt        <= '0;
                     shreg[idx] <= rx;
                     seen_one   <= seen_one | rx;
                     if ({1'b0, idx} == nbits - 1'b1) begin
                        state <= cfg_par_en ? RX_PAR : RX_STOP;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_PAR: begin
               if (tick) begin
                  if (cnt == LAST) begin
                     cnt      <= '0;
                     par_bit  <= rx;
                     seen_one <= seen_one | rx;
                     state    <= RX_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (cnt == LAST) begin
                     cnt          <= '0;
                     char_vld     <= 1'b1;
                     char_data    <= shreg;
                     char_tag.frm <= !rx;
                     char_tag.brk <= is_brk;
                     char_tag.par <= par_bad && !is_brk;
                     if (is_brk) begin
                        state <= RX_BRK;
                     end else if (!rx) begin
                        state    <= RX_DATA;
                        idx      <= '0;
                        shreg    <= '0;
                        seen_one <= 1'b0;
                     end else begin
                        state <= RX_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_BRK: begin
               if (rx) state <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_tagfifo.sv
module uart_rx_tagfifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned DEPTH  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     single,
   input  logic                     push,
   input  logic [TAG_W+DATA_W-1:0]  wdata,
   input  logic                     pop,
   output logic [TAG_W+DATA_W-1:0]  rdata,
   output logic [$clog2(DEPTH):0]   count,
   output logic [$clog2(DEPTH):0]   err_cnt,
   output logic                     full,
   output logic                     empty
);
   localparam int unsigned W     = TAG_W + DATA_W;
   localparam int unsigned PTR_W = $clog2(DEPTH);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic             push_ok, pop_ok;
   logic             w_err, r_err;

   assign empty   = (count == '0);
   assign full    = single ? !empty : (count == (PTR_W+1)'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign rdata   = mem[rptr];
   assign w_err   = |wdata[W-1:DATA_W];
   assign r_err   = |rdata[W-1:DATA_W];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         count   <= '0;
         err_cnt <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         case ({push_ok && w_err, pop_ok && r_err})
            2'b10:   err_cnt <= err_cnt + 1'b1;
            2'b01:   err_cnt <= err_cnt - 1'b1;
            default: err_cnt <= err_cnt;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
   import uart_rx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned FIFO_DEPTH  = 16,
   parameter int unsigned OSR         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              rxd,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_fifo_en,
   input  logic              rd_en,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned CNT_W = $clog2(FIFO_DEPTH) + 1;
   localparam int unsigned ENT_W = TAG_W + DATA_W;

   if (DATA_W < 8) begin : g_bad_width
      $error("uart_rx_lsr: DATA_W must be at least 8");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_rx_lsr: FIFO_DEPTH must be a power of two, at least 2");
   end
   if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
      $error("uart_rx_lsr: OSR must be a power of two, at least 4");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("uart_rx_lsr: SYNC_STAGES must be at least 1");
   end

   logic              rx_s;
   rx_state_e         rx_state;
   logic              char_vld;
   logic [DATA_W-1:0] char_data;
   rx_tag_t           char_tag;
   logic [ENT_W-1:0]  head;
   logic [CNT_W-1:0]  fifo_count;
   logic [CNT_W-1:0]  err_cnt;
   logic              fifo_full, fifo_empty;
   logic              ovr_q, sum_q;
   logic              rd_buf, rd_lsr;
   rx_tag_t           head_tag;

   assign rd_buf   = rd_en && !rd_sel;
   assign rd_lsr   = rd_en && rd_sel;
   assign head_tag = head[ENT_W-1:DATA_W];

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd),
      .q     (rx_s)
   );

   uart_rx_deframer #(.DATA_W(DATA_W), .OSR(OSR)) u_deframer (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (baud_tick),
      .rx          (rx_s),
      .cfg_len     (cfg_len),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_odd (cfg_par_odd),
      .char_vld    (char_vld),
      .char_data   (char_data),
      .char_tag    (char_tag),
      .state       (rx_state)
   );

   uart_rx_tagfifo #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .single  (!cfg_fifo_en),
      .push    (char_vld),
      .wdata   ({char_tag, char_data}),
      .pop     (rd_buf),
      .rdata   (head),
      .count   (fifo_count),
      .err_cnt (err_cnt),
      .full    (fifo_full),
      .empty   (fifo_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         sum_q <= 1'b0;
      end else begin
         if (char_vld && fifo_full) ovr_q <= 1'b1;
         else if (rd_lsr)           ovr_q <= 1'b0;

         if (char_vld && !fifo_full && (|char_tag)) sum_q <= 1'b1;
         else if (rd_lsr)                           sum_q <= (err_cnt != '0);
      end
   end

   always_comb begin
      rd_data = '0;
      if (!rd_sel) begin
         if (!fifo_empty) rd_data = head[DATA_W-1:0];
      end else begin
         rd_data[LSR_RDY] = !fifo_empty;
         rd_data[LSR_OVR] = ovr_q;
         rd_data[LSR_PAR] = !fifo_empty && head_tag.par;
         rd_data[LSR_FRM] = !fifo_empty && head_tag.frm;
         rd_data[LSR_BRK] = !fifo_empty && head_tag.brk;
         rd_data[LSR_SUM] = cfg_fifo_en && sum_q;
      end
   end
endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk
   import uart_rx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned FIFO_DEPTH = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         rd_en,
   input logic                         rd_sel,
   input logic                         cfg_fifo_en,
   input logic [DATA_W-1:0]            rd_data,
   input logic                         rx_s,
   input rx_state_e                    rx_state,
   input logic                         char_vld,
   input logic                         fifo_full,
   input logic [$clog2(FIFO_DEPTH):0]  fifo_count,
   input logic                         ovr_q
);
   AST_READY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sel |-> (rd_data[LSR_RDY] == (fifo_count != '0)));  // R1

   AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(char_vld && fifo_full));  // R2

   AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (char_vld && fifo_full && !(rd_en && !rd_sel)) |=> (fifo_count == $past(fifo_count)));  // R2

   AST_BRK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_state == RX_BRK && !rx_s) |=> (rx_state == RX_BRK));  // R6

   AST_SUM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_fifo_en && rd_sel) |-> !rd_data[LSR_SUM]);  // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= ($clog2(FIFO_DEPTH)+1)'(FIFO_DEPTH));  // R11
endmodule

bind uart_rx_lsr uart_rx_lsr_chk #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_en       (rd_en),
   .rd_sel      (rd_sel),
   .cfg_fifo_en (cfg_fifo_en),
   .rd_data     (rd_data),
   .rx_s        (rx_s),
   .rx_state    (rx_state),
   .char_vld    (char_vld),
   .fifo_full   (fifo_full),
   .fifo_count  (fifo_count),
   .ovr_q       (ovr_q)
);

// File: tb/uart_rx_lsr_tb.sv
module uart_rx_lsr_tb;
   localparam int BIT = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b1;
   logic       rxd = 1'b1;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_fifo_en = 1'b1;
   logic       rd_en = 1'b0;
   logic       rd_sel = 1'b0;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   uart_rx_lsr u_dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_fifo_en(cfg_fifo_en), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rxd = 1'b1; rd_en = 1'b0;
      cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_fifo_en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic do_read(input logic sel, output logic [7:0] v);
      @(negedge clk);
      rd_sel = sel; rd_en = 1'b1;
      #1 v = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      rxd = b;
      repeat (BIT) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] d, input int n);
      for (int i = 0; i < n; i++) send_bit(d[i]);
   endtask

   task automatic send_frame(input logic [7:0] d, input int n, input logic par_on,
                             input logic par_val, input logic stop);
      @(negedge clk);
      send_bit(1'b0);
      send_bits(d, n);
      if (par_on) send_bit(par_val);
      send_bit(stop);
      rxd = 1'b1;
   endtask

   task automatic idle(input int bits);
      rxd = 1'b1;
      repeat (bits * BIT) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      do_reset();
      do_read(1'b1, v); check("R1 reset status", v, 8'h00);
      do_read(1'b0, v); check("R10 empty buffer read", v, 8'h00);
      do_read(1'b1, v); check("R10 empty read leaves status", v, 8'h00);
   endtask

   task automatic t_basic_and_length();
      logic [7:0] v;
      do_reset();
      send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b1); idle(2);
      do_read(1'b1, v); check("R1 ready after char", v, 8'h01);
      do_read(1'b0, v); check("R10 data 8 bit", v, 8'hA5);
      do_read(1'b1, v); check("R1 ready cleared after pop", v, 8'h00);
      cfg_len = 2'd0;
      send_frame(8'hF6, 5, 1'b0, 1'b0, 1'b1); idle(2);
      do_read(1'b0, v); check("R9 5-bit right aligned", v, 8'h16);
      cfg_len = 2'd2;
      send_frame(8'hD5, 7, 1'b0, 1'b0, 1'b1); idle(2);
      do_read(1'b0, v); check("R9 7-bit right aligned", v, 8'h55);
   endtask

   task automatic t_false_start();
      logic [7:0] v;
      do_reset();
      @(negedge clk);
      rxd = 1'b0; repeat (5) @(negedge clk);
      idle(4);
      do_read(1'b1, v); check("R8 glitch stores nothing", v, 8'h00);
      send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1); idle(2);
      do_read(1'b0, v); check("R8 next char after glitch", v, 8'h3C);
   endtask

   task automatic t_parity_summary();
      logic [7:0] v;
      do_reset();
      cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
      send_frame(8'h5B, 8, 1'b1, ~(^8'h5B), 1'b1); idle(1);
      send_frame(8'h5A, 8, 1'b1, ^8'h5A, 1'b1); idle(2);
      do_read(1'b1, v); check("R3 even parity error head", v, 8'h85);
      do_read(1'b0, v); check("R10 pop errored char", v, 8'h5B);
      do_read(1'b1, v); check("R7 summary held until read", v, 8'h81);
      do_read(1'b0, v); check("R3 good even parity data", v, 8'h5A);
      do_read(1'b1, v); check("R7 summary cleared", v, 8'h00);
      cfg_par_odd = 1'b1;
      send_frame(8'h01, 8, 1'b1, 1'b0, 1'b1); idle(2);
      do_read(1'b1, v); check("R3 odd parity ok", v, 8'h01);
      do_read(1'b0, v);
      send_frame(8'h03, 8, 1'b1, 1'b0, 1'b1); idle(2);
      do_read(1'b1, v); check("R3 odd parity error", v, 8'h85);
   endtask

   task automatic t_framing_resync();
      logic [7:0] v;
      do_reset();
      send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0);
      rxd = 1'b0;
      send_bits(8'hA5, 8);
      send_bit(1'b1);
      idle(2);
      do_read(1'b1, v); check("R4 framing on head", v, 8'h89);
      do_read(1'b0, v); check("R4 framed char data", v, 8'h3C);
      do_read(1'b1, v); check("R5 resync char clean", v, 8'h81);
      do_read(1'b0, v); check("R5 resync char data", v, 8'hA5);
      do_read(1'b1, v); check("R5 nothing else stored", v, 8'h00);
   endtask

   task automatic t_break();
      logic [7:0] v;
      do_reset();
      @(negedge clk);
      rxd = 1'b0;
      repeat (40 * BIT) @(negedge clk);
      do_read(1'b1, v); check("R6 break tags", v, 8'h99);
      do_read(1'b0, v); check("R6 break data zero", v, 8'h00);
      do_read(1'b1, v); check("R6 parked while low", v, 8'h80);
      idle(2);
      send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1); idle(2);
      do_read(1'b0, v); check("R6 receive after mark", v, 8'h5A);
   endtask

   task automatic t_overrun();
      logic [7:0] v;
      do_reset();
      for (int i = 0; i < 17; i++) send_frame(8'h30 + 8'(i), 8, 1'b0, 1'b0, 1'b1);
      idle(2);
      do_read(1'b1, v); check("R2 overrun set", v, 8'h03);
      do_read(1'b1, v); check("R2 overrun cleared by read", v, 8'h01);
      for (int i = 0; i < 16; i++) begin
         do_read(1'b0, v); check("R2 contents kept", v, 8'h30 + 8'(i));
      end
      do_read(1'b1, v); check("R2 new char discarded", v, 8'h00);
   endtask

   task automatic t_fifo_off();
      logic [7:0] v;
      do_reset();
      cfg_fifo_en = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
      send_frame(8'h5B, 8, 1'b1, ~(^8'h5B), 1'b1); idle(1);
      send_frame(8'h11, 8, 1'b1, ^8'h11, 1'b1); idle(2);
      do_read(1'b1, v); check("R11 single entry overrun, R7 summary masked", v, 8'h07);
      do_read(1'b0, v); check("R11 first char kept", v, 8'h5B);
      do_read(1'b1, v); check("R11 empty after pop", v, 8'h00);
   endtask

   initial begin
      t_reset();
      t_basic_and_length();
      t_false_start();
      t_parity_summary();
      t_framing_resync();
      t_break();
      t_overrun();
      t_fifo_off();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule